// File: doc/BRIEF.md
# Boot Block Top-Swap Address Remapper

This block sits in the address path to a firmware flash device. While a new top boot block is written into the flash, the processor must still boot from a good copy. The block keeps a swap-enable bit. When that bit is in effect, it inverts address bit 16 on firmware-device cycles that fall in the top 128 KB of the 32-bit space. Processor fetches from FFFF0000h–FFFFFFFFh then reach FFFE0000h–FFFEFFFFh, where software has placed a backup copy of the boot block.

Software sets and clears the swap bit through a small write port. A lock-down bit, once set, freezes the swap bit. An external strap forces swap mode, and while the strap is asserted software cannot clear the stored bit. The swap bit is mirrored in an always-powered retained register, and the lock lives there too. Each has its own reset. A main-domain reset reloads the swap bit from the retained copy, so an interrupted update still boots from the backup block. A retained-domain reset clears everything.

Top module: `boot_swap_remap`

## Requirements
- R1: After both resets, swapActive and lockActive are 0 and every address passes through unchanged.
- R2: With swap in effect, a firmware cycle (fwCycle=1) to FFFF0000h–FFFFFFFFh leaves with bit 16 cleared (FFFFxxxxh becomes FFFExxxxh).
- R3: With swap in effect, a firmware cycle to FFFE0000h–FFFEFFFFh leaves with bit 16 set.
- R4: With swap not in effect, firmware cycles in the top 128 KB leave unchanged.
- R5: Cycles with fwCycle=0 leave unchanged whatever the swap state.
- R6: Addresses below FFFE0000h leave unchanged whatever the swap state.
- R7: swapActive is the stored swap bit ORed with strapForce. While strapForce=1, a write of 0 to the swap bit is ignored, and a write of 1 is accepted.
- R8: A swap write (swapWrEn=1, value swapWrVal) takes effect at the next clock edge. Once lockActive=1, swap writes are ignored.
- R9: lockSet=1 sets lockActive at the next edge. Only a retained-domain reset clears it, and a main-domain reset leaves it set.
- R10: A main-domain reset (mainRstN=0) reloads the stored swap bit from the retained copy. Writes are ignored while either reset is asserted.
- R11: A retained-domain reset (retRstN=0) clears the stored swap bit, its retained copy and the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mainRstN | input | 1 | Main-domain synchronous reset, active low |
| retRstN | input | 1 | Retained-domain synchronous reset, active low |
| strapForce | input | 1 | Strap that forces swap mode |
| swapWrEn | input | 1 | Write strobe for the swap bit |
| swapWrVal | input | 1 | Value written to the swap bit |
| lockSet | input | 1 | Sets the lock-down bit |
| addrIn | input | 32 | Incoming cycle address |
| fwCycle | input | 1 | Marks the cycle as directed to the firmware device |
| addrOut | output | 32 | Remapped address |
| swapActive | output | 1 | Swap mode currently in effect |
| lockActive | output | 1 | Lock-down bit |

## Verification
The hardest situation to reach from the ports is a main-power loss partway through an update. The swap bit must come back from the retained copy after a main reset, with the lock and the strap interacting. The bench drives random sequences in which main resets, retained resets, strap toggles, lock sets and swap writes interleave. A reference model applies the same rules. Directed sequences add the cases that matter most: a main reset with swap set and the lock held, a clear attempted under the strap, and writes after lock-down.

// File: rtl/boot_swap_pkg.sv
package boot_swap_pkg;

  // strobes from control to the address datapath
  typedef struct packed {
    logic remapEn;
  } pathStrb_t;

  // strobes from control to the retained register
  typedef struct packed {
    logic wrSwap;
    logic swapVal;
    logic setLock;
  } retWr_t;

endpackage

// File: rtl/boot_swap_retain.sv
module boot_swap_retain
  import boot_swap_pkg::*;
(
  input  logic   clk,
  input  logic   retRstN,
  input  retWr_t wr,
  output logic   retSwap,
  output logic   retLock
);

  always_ff @(posedge clk) begin
    if (!retRstN) begin
      retSwap <= 1'b0;
      retLock <= 1'b0;
    end else begin
      if (wr.wrSwap)  retSwap <= wr.swapVal;
      if (wr.setLock) retLock <= 1'b1;
    end
  end

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!retRstN)
    retLock |=> retLock);

endmodule

// File: rtl/boot_swap_ctrl.sv
module boot_swap_ctrl
  import boot_swap_pkg::*;
(
  input  logic      clk,
  input  logic      mainRstN,
  input  logic      retRstN,
  input  logic      strapForce,
  input  logic      swapWrEn,
  input  logic      swapWrVal,
  input  logic      lockSet,
  input  logic      retSwap,
  input  logic      retLock,
  output retWr_t    retWr,
  output pathStrb_t pathStrb,
  output logic      swapActive
);

  logic swapMain;
  logic inReset;
  logic writeOk;

  assign inReset = !mainRstN || !retRstN;
  // a clear is refused while the strap forces swap mode
  assign writeOk = !inReset && swapWrEn && !retLock && (swapWrVal || !strapForce);

  always_ff @(posedge clk) begin
    if (!retRstN)       swapMain <= 1'b0;
    else if (!mainRstN) swapMain <= retSwap;
    else if (writeOk)   swapMain <= swapWrVal;
  end

  always_comb begin
    retWr.wrSwap  = writeOk;
    retWr.swapVal = swapWrVal;
    retWr.setLock = !inReset && lockSet;
  end

  assign swapActive       = swapMain || strapForce;
  assign pathStrb.remapEn = swapActive;

  // R8
  locked_hold_chk: assert property (@(posedge clk) disable iff (inReset)
    (retLock && swapWrEn) |=> $stable(swapMain));

  // R7
  strap_no_clear_chk: assert property (@(posedge clk) disable iff (inReset)
    (strapForce && swapMain) |=> swapMain);

  // R10
  main_reload_chk: assert property (@(posedge clk) disable iff (!retRstN)
    !mainRstN |=> (swapMain == retSwap));

  // R10
  mirror_match_chk: assert property (@(posedge clk) disable iff (inReset)
    swapMain == retSwap);

endmodule

// File: rtl/boot_swap_path.sv
module boot_swap_path
  import boot_swap_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SWAP_BIT = 16
) (
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              fwCycle,
  input  pathStrb_t         strb,
  output logic [ADDR_W-1:0] addrOut
);

  localparam int WIN_LO = SWAP_BIT + 1;
  localparam logic [ADDR_W-1:0] FLIP_MASK = ADDR_W'(1) << SWAP_BIT;

  logic inTopWin;

  assign inTopWin = &addrIn[ADDR_W-1:WIN_LO];
  assign addrOut  = (fwCycle && strb.remapEn && inTopWin) ? (addrIn ^ FLIP_MASK) : addrIn;

endmodule

// File: rtl/boot_swap_remap.sv
module boot_swap_remap
  import boot_swap_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int SWAP_BIT = 16
) (
  input  logic              clk,
  input  logic              mainRstN,
  input  logic              retRstN,
  input  logic              strapForce,
  input  logic              swapWrEn,
  input  logic              swapWrVal,
  input  logic              lockSet,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              fwCycle,
  output logic [ADDR_W-1:0] addrOut,
  output logic              swapActive,
  output logic              lockActive
);

  localparam int WIN_LO = SWAP_BIT + 1;

  retWr_t    retWr;
  pathStrb_t pathStrb;
  logic      retSwap;
  logic      retLock;

  boot_swap_retain u_retain (
    .clk     (clk),
    .retRstN (retRstN),
    .wr      (retWr),
    .retSwap (retSwap),
    .retLock (retLock)
  );

  boot_swap_ctrl u_ctrl (
    .clk        (clk),
    .mainRstN   (mainRstN),
    .retRstN    (retRstN),
    .strapForce (strapForce),
    .swapWrEn   (swapWrEn),
    .swapWrVal  (swapWrVal),
    .lockSet    (lockSet),
    .retSwap    (retSwap),
    .retLock    (retLock),
    .retWr      (retWr),
    .pathStrb   (pathStrb),
    .swapActive (swapActive)
  );

  boot_swap_path #(.ADDR_W(ADDR_W), .SWAP_BIT(SWAP_BIT)) u_path (
    .addrIn  (addrIn),
    .fwCycle (fwCycle),
    .strb    (pathStrb),
    .addrOut (addrOut)
  );

  assign lockActive = retLock;

  // R5
  non_fw_pass_chk: assert property (@(posedge clk) disable iff (!retRstN)
    !fwCycle |-> (addrOut == addrIn));

  // R6
  low_addr_pass_chk: assert property (@(posedge clk) disable iff (!retRstN)
    !(&addrIn[ADDR_W-1:WIN_LO]) |-> (addrOut == addrIn));

  // R2
  swap_flip_chk: assert property (@(posedge clk) disable iff (!retRstN)
    (fwCycle && swapActive && (&addrIn[ADDR_W-1:WIN_LO]))
      |-> (addrOut[SWAP_BIT] != addrIn[SWAP_BIT]));

  // R4
  no_swap_pass_chk: assert property (@(posedge clk) disable iff (!retRstN)
    !swapActive |-> (addrOut == addrIn));

endmodule

// File: tb/tb_boot_swap_remap.sv
module tb_boot_swap_remap;

  logic        clk = 1'b0;
  logic        mainRstN, retRstN, strapForce, swapWrEn, swapWrVal, lockSet, fwCycle;
  logic [31:0] addrIn, addrOut;
  logic        swapActive, lockActive;

  int checks = 0;
  int failures = 0;
  bit mSwap = 1'b0;
  bit mLock = 1'b0;

  always #10 clk = ~clk;

  boot_swap_remap dut (
    .clk(clk), .mainRstN(mainRstN), .retRstN(retRstN), .strapForce(strapForce),
    .swapWrEn(swapWrEn), .swapWrVal(swapWrVal), .lockSet(lockSet),
    .addrIn(addrIn), .fwCycle(fwCycle), .addrOut(addrOut),
    .swapActive(swapActive), .lockActive(lockActive)
  );

  function automatic logic [31:0] expAddr(logic [31:0] a, logic fw, logic eff);
    if (fw && eff && (a[31:17] == 15'h7FFF)) return a ^ 32'h0001_0000;
    return a;
  endfunction

  function automatic string addrReq(logic [31:0] a, logic fw, logic eff);
    if (!fw) return "R5";
    if (a[31:17] != 15'h7FFF) return "R6";
    if (!eff) return "R4";
    return a[16] ? "R2" : "R3";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    logic eff;
    eff = mSwap || strapForce;
    chk((req == "") ? addrReq(addrIn, fwCycle, eff) : req, addrOut, expAddr(addrIn, fwCycle, eff));
    chk((req == "") ? "R7" : req, 32'(swapActive), 32'(eff));
    chk((req == "") ? "R9" : req, 32'(lockActive), 32'(mLock));
  endtask

  // model the edge that follows the currently driven inputs
  task automatic stepModel();
    if (!retRstN) begin
      mSwap = 1'b0; mLock = 1'b0;
    end else if (mainRstN) begin
      if (swapWrEn && !mLock && (swapWrVal || !strapForce)) mSwap = swapWrVal;
      if (lockSet) mLock = 1'b1;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    stepModel();
    @(negedge clk);
  endtask

  task automatic idle();
    mainRstN = 1; retRstN = 1; swapWrEn = 0; swapWrVal = 0; lockSet = 0;
  endtask

  task automatic probe(logic [31:0] a, logic fw, string req);
    addrIn = a; fwCycle = fw; #1; checkAll(req);
  endtask

  initial begin
    #(20 * 200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    mainRstN = 0; retRstN = 0; strapForce = 0; swapWrEn = 0; swapWrVal = 0;
    lockSet = 0; fwCycle = 1; addrIn = 32'hFFFF_FFF0;
    @(negedge clk); cyc(); cyc();
    idle();
    // R1: reset state
    probe(32'hFFFF_FFF0, 1, "R1");
    probe(32'hFFFE_1234, 1, "R1");

    // R8: write swap takes effect at next edge
    swapWrEn = 1; swapWrVal = 1; cyc(); idle();
    probe(32'hFFFF_FFF0, 1, "R2");
    probe(32'hFFFE_0010, 1, "R3");
    probe(32'hFFFD_FFFF, 1, "R6");
    probe(32'hFFFF_0000, 0, "R5");

    // R10: main reset keeps swap from retained copy
    mainRstN = 0; cyc(); cyc(); idle();
    probe(32'hFFFF_ABCD, 1, "R10");

    // R7: strap blocks clear
    strapForce = 1; swapWrEn = 1; swapWrVal = 0; cyc(); idle();
    strapForce = 0;
    probe(32'hFFFF_0001, 1, "R7");

    // R8/R9: lock, then clear ignored
    lockSet = 1; cyc(); idle();
    swapWrEn = 1; swapWrVal = 0; cyc(); idle();
    probe(32'hFFFF_0002, 1, "R8");
    mainRstN = 0; cyc(); idle();
    probe(32'hFFFF_0003, 1, "R9");

    // R11: retained reset clears all
    retRstN = 0; cyc(); idle();
    probe(32'hFFFF_0004, 1, "R11");
    swapWrEn = 1; swapWrVal = 1; cyc(); idle();
    swapWrEn = 1; swapWrVal = 0; cyc(); idle();
    probe(32'hFFFF_0005, 1, "R4");

    // random mix
    for (int i = 0; i < 1500; i++) begin
      int r;
      idle();
      r = $urandom % 100;
      if (r < 2) retRstN = 0;
      else if (r < 5) mainRstN = 0;
      if (($urandom % 100) < 2) lockSet = 1;
      if (($urandom % 100) < 8) strapForce = ~strapForce;
      if (($urandom % 100) < 30) begin swapWrEn = 1; swapWrVal = 1'($urandom); end
      fwCycle = (($urandom % 4) != 0);
      case ($urandom % 4)
        0: addrIn = {16'hFFFF, 16'($urandom)};
        1: addrIn = {16'hFFFE, 16'($urandom)};
        2: addrIn = $urandom;
        default: addrIn = (($urandom % 2) != 0) ? 32'hFFFD_FFFF : 32'hFFFE_0000;
      endcase
      #1; checkAll("");
      cyc();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule